// File: doc/BRIEF.md
# Parity-Indexed Page Translation Cache

This block keeps two recent virtual-to-physical page translations for an instruction fetch path and sits in front of a page-table walker. A fetch address is split into a virtual page number (the address bits above the page shift) and an in-page offset. One of the two slots is chosen by the XOR-reduction of the whole virtual page number. Because the slot depends on the parity of the full number and not on its lowest bit, two busy pages that differ in any single bit fall into different slots and do not evict each other.

When the chosen slot holds the page, the physical address is answered in the same cycle. When it does not, the fetch port drops its ready. The block sends one request to the walker and waits for the walker's answer, then answers the fetch one cycle later. A good answer refills the slot. A faulting answer is passed to the fetch side and leaves the slot as it was.

An empty slot holds an all-ones tag that is one bit wider than any page number, so no real page can match it. Software-style maintenance is driven by two pulses. One empties both slots. The other empties every slot whose page lies inside an inclusive byte range given as start and size. Each slot counts its own hits and misses.

Top module: `fetch_xlat_cache`

## Requirements
- R1: After reset, fetch_ready is 1, walk_req_valid and out_valid are 0, both slots are empty and all four counters read 0.
- R2: The slot index is the XOR of all bits fetch_addr[31:12]. On an accepted fetch that matches the selected slot, out_valid is 1 in the same cycle. out_paddr is {stored page, fetch_addr[11:0]}, out_word is fetch_addr[11:2], and no walker request follows.
- R3: On a miss, fetch_ready goes low from the next cycle. In the next cycle walk_req_valid rises with walk_req_vpn = fetch_addr[31:12], and both stay steady until walk_req_ready. walk_rsp_ready is then 1 until walk_rsp_valid. out_valid rises in the cycle after the response, and fetch_ready returns in the cycle after that.
- R4: A good walker response fills the selected slot, so a later fetch of the same page hits without a walk. The miss answer carries out_fault = 0 and out_paddr = {walk_rsp_ppn, offset}.
- R5: Pages with different parity occupy both slots at once. A page with the same parity as a resident page replaces it.
- R6: A faulting walker response gives out_valid with out_fault = 1 and leaves both slots unchanged.
- R7: A pulse on inv_all empties both slots.
- R8: A pulse on inv_range empties each slot whose page lies in [inv_start >> 12, (inv_start + inv_size - 1) >> 12], both bounds inclusive, using arithmetic that does not wrap. Other slots are kept. A size of 0 empties nothing.
- R9: hit_count and miss_count hold one CNT_W field per slot, with slot 0 in the low bits. On each accepted fetch, the field of the selected slot that matches the outcome increases by 1.
- R10: An invalidate in the same cycle as a fill is applied after the fill. The filled page is dropped if the invalidate covers it and kept otherwise.
- R11: A fetch that hits in the same cycle as an invalidate is answered from the translation held before the invalidate.
- R12: A fetch of page 0xFFFFF right after reset misses, because an empty slot never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch lookup present |
| fetch_ready | output | 1 | Lookup can be accepted |
| fetch_addr | input | 32 | Virtual fetch address |
| out_valid | output | 1 | Translation answer present |
| out_fault | output | 1 | Answer carries a walker fault |
| out_paddr | output | 32 | Physical page with in-page offset |
| out_word | output | 10 | Word index inside the page |
| walk_req_valid | output | 1 | Walk request present |
| walk_req_ready | input | 1 | Walker takes the request |
| walk_req_vpn | output | 20 | Page number to translate |
| walk_rsp_valid | input | 1 | Walker answer present |
| walk_rsp_ready | output | 1 | Block waits for an answer |
| walk_rsp_ppn | input | 20 | Physical page from walker |
| walk_rsp_fault | input | 1 | Walker reports a fault |
| inv_all | input | 1 | Empty both slots |
| inv_range | input | 1 | Empty slots inside a range |
| inv_start | input | 32 | Range start byte address |
| inv_size | input | 32 | Range size in bytes |
| hit_count | output | 32 | Per-slot hit counters |
| miss_count | output | 32 | Per-slot miss counters |

## Verification
Two functions can fall in the same cycle here. A slot refill from the walker can coincide with a ranged or global invalidate, and a hitting lookup can coincide with an invalidate. The bench raises the invalidate in the exact cycle the walker answer is presented. It does this once with a range that covers the refilled page and once with a range that misses it, and then judges by whether the next fetch of that page walks again. For the lookup case it asserts inv_all together with a hitting fetch, checks that the answer still carries the old page, and checks that the following fetch misses.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2,
    S_RESP = 2'd3
  } xlat_state_e;

  // first page touched by a byte range
  function automatic logic [63:0] span_first(input logic [63:0] start, input int unsigned sh);
    return start >> sh;
  endfunction

  // last page touched by a byte range of nonzero size
  function automatic logic [63:0] span_last(input logic [63:0] start, input logic [63:0] size,
                                            input int unsigned sh);
    return (start + size - 64'd1) >> sh;
  endfunction

  function automatic logic in_span(input logic [63:0] page, input logic [63:0] lo,
                                   input logic [63:0] hi);
    return (page >= lo) && (page <= hi);
  endfunction

endpackage

// File: rtl/xlat_entry.sv
module xlat_entry
  import xlat_pkg::*;
#(
  parameter int TAG_W = 33,
  parameter int PPN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             kill_all,
  input  logic             kill_rng,
  input  logic [63:0]      span_lo,
  input  logic [63:0]      span_hi,
  output logic [TAG_W-1:0] tag_q,
  output logic [PPN_W-1:0] ppn_q
);

  // the invalidate is judged against the tag the slot would hold after a fill
  logic [TAG_W-1:0] cand_tag;
  logic             drop;

  assign cand_tag = fill_en ? fill_tag : tag_q;
  assign drop     = kill_all | (kill_rng & in_span(64'(cand_tag), span_lo, span_hi));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '1;
      ppn_q <= '0;
    end else begin
      tag_q <= drop ? '1 : cand_tag;
      if (fill_en) ppn_q <= fill_ppn;
    end
  end

endmodule

// File: rtl/xlat_counter.sv
module xlat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (bump) count <= count + 1'b1;
  end

endmodule

// File: rtl/fetch_xlat_cache.sv
module fetch_xlat_cache
  import xlat_pkg::*;
#(
  parameter int AW         = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int PPN_W      = 20,
  parameter int CNT_W      = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fetch_valid,
  output logic                        fetch_ready,
  input  logic [AW-1:0]               fetch_addr,
  output logic                        out_valid,
  output logic                        out_fault,
  output logic [PPN_W+PAGE_SHIFT-1:0] out_paddr,
  output logic [PAGE_SHIFT-3:0]       out_word,
  output logic                        walk_req_valid,
  input  logic                        walk_req_ready,
  output logic [AW-PAGE_SHIFT-1:0]    walk_req_vpn,
  input  logic                        walk_rsp_valid,
  output logic                        walk_rsp_ready,
  input  logic [PPN_W-1:0]            walk_rsp_ppn,
  input  logic                        walk_rsp_fault,
  input  logic                        inv_all,
  input  logic                        inv_range,
  input  logic [AW-1:0]               inv_start,
  input  logic [AW-1:0]               inv_size,
  output logic [2*CNT_W-1:0]          hit_count,
  output logic [2*CNT_W-1:0]          miss_count
);

  localparam int VPN_W   = AW - PAGE_SHIFT;
  localparam int TAG_W   = VPN_W + 1;   // one spare bit keeps the empty marker unreachable
  localparam int ENTRIES = 2;

  xlat_state_e      state;
  logic [AW-1:0]    pend_addr;
  logic [PPN_W-1:0] rsp_ppn_q;
  logic             rsp_fault_q;

  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [PPN_W-1:0] ppn_q [ENTRIES];

  logic [VPN_W-1:0] vpn_in, pend_vpn;
  logic             idx_in, pend_idx;
  logic             accept, lookup_hit, fill_go, rng_go;
  logic [63:0]      span_lo, span_hi;

  assign vpn_in   = fetch_addr[AW-1:PAGE_SHIFT];
  assign pend_vpn = pend_addr[AW-1:PAGE_SHIFT];
  assign idx_in   = ^vpn_in;
  assign pend_idx = ^pend_vpn;

  assign fetch_ready    = (state == S_IDLE);
  assign accept         = fetch_valid && fetch_ready;
  assign lookup_hit     = (tag_q[idx_in] == TAG_W'(vpn_in));
  assign fill_go        = (state == S_WAIT) && walk_rsp_valid && !walk_rsp_fault;
  assign walk_req_valid = (state == S_REQ);
  assign walk_rsp_ready = (state == S_WAIT);
  assign walk_req_vpn   = pend_vpn;

  assign rng_go  = inv_range && (inv_size != '0);
  assign span_lo = span_first(64'(inv_start), PAGE_SHIFT);
  assign span_hi = span_last(64'(inv_start), 64'(inv_size), PAGE_SHIFT);

  // answer: same cycle on a hit, registered after a walk
  always_comb begin
    if (state == S_RESP) begin
      out_valid = 1'b1;
      out_fault = rsp_fault_q;
      out_paddr = {rsp_ppn_q, pend_addr[PAGE_SHIFT-1:0]};
      out_word  = pend_addr[PAGE_SHIFT-1:2];
    end else begin
      out_valid = accept && lookup_hit;
      out_fault = 1'b0;
      out_paddr = {ppn_q[idx_in], fetch_addr[PAGE_SHIFT-1:0]};
      out_word  = fetch_addr[PAGE_SHIFT-1:2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      pend_addr   <= '0;
      rsp_ppn_q   <= '0;
      rsp_fault_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept && !lookup_hit) begin
          pend_addr <= fetch_addr;
          state     <= S_REQ;
        end
        S_REQ:  if (walk_req_ready) state <= S_WAIT;
        S_WAIT: if (walk_rsp_valid) begin
          rsp_ppn_q   <= walk_rsp_ppn;
          rsp_fault_q <= walk_rsp_fault;
          state       <= S_RESP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic hit_bump, miss_bump;
    assign hit_bump  = accept && (idx_in == 1'(e)) && lookup_hit;
    assign miss_bump = accept && (idx_in == 1'(e)) && !lookup_hit;

    xlat_entry #(.TAG_W(TAG_W), .PPN_W(PPN_W)) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .fill_en  (fill_go && (pend_idx == 1'(e))),
      .fill_tag (TAG_W'(pend_vpn)),
      .fill_ppn (walk_rsp_ppn),
      .kill_all (inv_all),
      .kill_rng (rng_go),
      .span_lo  (span_lo),
      .span_hi  (span_hi),
      .tag_q    (tag_q[e]),
      .ppn_q    (ppn_q[e])
    );

    xlat_counter #(.W(CNT_W)) u_hits (
      .clk(clk), .rst_n(rst_n), .bump(hit_bump), .count(hit_count[e*CNT_W +: CNT_W])
    );
    xlat_counter #(.W(CNT_W)) u_miss (
      .clk(clk), .rst_n(rst_n), .bump(miss_bump), .count(miss_count[e*CNT_W +: CNT_W])
    );
  end

endmodule

// File: rtl/xlat_chk.sv
module xlat_chk #(
  parameter int TAG_W = 21,
  parameter int VPN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_valid,
  input logic             fetch_ready,
  input logic             out_valid,
  input logic             out_fault,
  input logic             walk_req_valid,
  input logic             walk_req_ready,
  input logic [VPN_W-1:0] walk_req_vpn,
  input logic             walk_rsp_valid,
  input logic             walk_rsp_ready,
  input logic             walk_rsp_fault,
  input logic             inv_all,
  input logic             lookup_hit,
  input logic             fill_go,
  input logic [TAG_W-1:0] tag0,
  input logic [TAG_W-1:0] tag1
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid && !walk_req_ready |=> walk_req_valid && $stable(walk_req_vpn)); // R3

  AST_STALL_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid || walk_rsp_ready) |-> !fetch_ready); // R3

  AST_RSP_THEN_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    walk_rsp_valid && walk_rsp_ready |=> out_valid && !fetch_ready); // R3

  AST_HIT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fetch_ready && lookup_hit |=> fetch_ready && !walk_req_valid); // R2

  AST_FILL_CLEAN_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> out_valid && !out_fault); // R4

  AST_FAULT_KEEPS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    walk_rsp_valid && walk_rsp_ready && walk_rsp_fault && !inv_all
    |=> $stable(tag0) && $stable(tag1) && out_fault); // R6

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (&tag0) && (&tag1)); // R7

endmodule

bind fetch_xlat_cache xlat_chk #(.TAG_W(TAG_W), .VPN_W(VPN_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fetch_valid    (fetch_valid),
  .fetch_ready    (fetch_ready),
  .out_valid      (out_valid),
  .out_fault      (out_fault),
  .walk_req_valid (walk_req_valid),
  .walk_req_ready (walk_req_ready),
  .walk_req_vpn   (walk_req_vpn),
  .walk_rsp_valid (walk_rsp_valid),
  .walk_rsp_ready (walk_rsp_ready),
  .walk_rsp_fault (walk_rsp_fault),
  .inv_all        (inv_all),
  .lookup_hit     (lookup_hit),
  .fill_go        (fill_go),
  .tag0           (tag_q[0]),
  .tag1           (tag_q[1])
);

// File: tb/sim_fetch_xlat_cache.sv
`timescale 1ns/100ps
module sim_fetch_xlat_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        walk_req_ready = 1'b0;
  logic        walk_rsp_valid = 1'b0;
  logic [19:0] walk_rsp_ppn = '0;
  logic        walk_rsp_fault = 1'b0;
  logic        inv_all = 1'b0;
  logic        inv_range = 1'b0;
  logic [31:0] inv_start = '0;
  logic [31:0] inv_size = '0;

  logic        fetch_ready, out_valid, out_fault, walk_req_valid, walk_rsp_ready;
  logic [31:0] out_paddr;
  logic [9:0]  out_word;
  logic [19:0] walk_req_vpn;
  logic [31:0] hit_count, miss_count;

  always #2.5 clk = ~clk;

  fetch_xlat_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .out_valid(out_valid), .out_fault(out_fault), .out_paddr(out_paddr), .out_word(out_word),
    .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready), .walk_req_vpn(walk_req_vpn),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ready(walk_rsp_ready),
    .walk_rsp_ppn(walk_rsp_ppn), .walk_rsp_fault(walk_rsp_fault),
    .inv_all(inv_all), .inv_range(inv_range), .inv_start(inv_start), .inv_size(inv_size),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // bench model of the two slots and counters
  bit          m_val [2];
  logic [19:0] m_vpn [2];
  logic [19:0] m_ppn [2];
  int          m_hit [2];
  int          m_miss[2];

  function automatic logic [19:0] walker_map(input logic [19:0] v);
    return v ^ 20'h5A3C1;
  endfunction

  function automatic bit slot_of(input logic [19:0] v);
    bit p = 1'b0;
    for (int i = 0; i < 20; i++) p = p ^ v[i];
    return p;
  endfunction

  function automatic bit covered(input logic [19:0] v, input logic [31:0] s, input logic [31:0] sz);
    longint unsigned first_pg, last_pg;
    if (sz == 0) return 1'b0;
    first_pg = longint'(s) / 4096;
    last_pg  = (longint'(s) + longint'(sz) - 1) / 4096;
    return (longint'(v) >= first_pg) && (longint'(v) <= last_pg);
  endfunction

  function automatic void model_inv(input bit ia, input bit ir, input logic [31:0] s,
                                    input logic [31:0] sz);
    for (int e = 0; e < 2; e++)
      if (m_val[e] && (ia || (ir && covered(m_vpn[e], s, sz)))) m_val[e] = 1'b0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_counts(input string req);
    check(req, {16'h0, hit_count[15:0]},   32'(m_hit[0]));
    check(req, {16'h0, hit_count[31:16]},  32'(m_hit[1]));
    check(req, {16'h0, miss_count[15:0]},  32'(m_miss[0]));
    check(req, {16'h0, miss_count[31:16]}, 32'(m_miss[1]));
  endtask

  // One fetch. On a hit the invalidate inputs are raised together with the lookup;
  // on a miss they are raised together with the walker answer.
  task automatic fetch(input logic [31:0] a, input bit flt, input bit ia, input bit ir,
                       input logic [31:0] s, input logic [31:0] sz, input string req);
    logic [19:0] v;
    bit          k;
    bit          hit;
    v   = a[31:12];
    k   = slot_of(v);
    hit = m_val[k] && (m_vpn[k] == v);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    if (hit) begin
      inv_all = ia; inv_range = ir; inv_start = s; inv_size = sz;
      #1;
      check({req, " hit valid"}, {31'b0, out_valid}, 32'd1);
      check({req, " hit paddr"}, out_paddr, {m_ppn[k], a[11:0]});
      check({req, " hit word"}, {22'b0, out_word}, {22'b0, a[11:2]});
      m_hit[k]++;
      @(posedge clk); #1;
      fetch_valid = 1'b0;
      inv_all = 1'b0; inv_range = 1'b0;
      check({req, " hit no walk"}, {31'b0, walk_req_valid}, 32'd0);
      model_inv(ia, ir, s, sz);
    end else begin
      #1;
      check({req, " miss no answer"}, {31'b0, out_valid}, 32'd0);
      m_miss[k]++;
      @(posedge clk); #1;
      fetch_valid = 1'b0;
      check({req, " R3 stall"}, {31'b0, fetch_ready}, 32'd0);
      check({req, " R3 req vpn"}, {walk_req_valid, 11'b0, walk_req_vpn}, {1'b1, 11'b0, v});
      @(posedge clk); #1;
      check({req, " R3 req held"}, {walk_req_valid, 11'b0, walk_req_vpn}, {1'b1, 11'b0, v});
      walk_req_ready = 1'b1;
      @(posedge clk); #1;
      walk_req_ready = 1'b0;
      check({req, " R3 rsp ready"}, {30'b0, walk_req_valid, walk_rsp_ready}, 32'd1);
      walk_rsp_valid = 1'b1;
      walk_rsp_ppn   = walker_map(v);
      walk_rsp_fault = flt;
      inv_all = ia; inv_range = ir; inv_start = s; inv_size = sz;
      @(posedge clk); #1;
      walk_rsp_valid = 1'b0; walk_rsp_fault = 1'b0;
      inv_all = 1'b0; inv_range = 1'b0;
      check({req, " miss answer"}, {30'b0, out_valid, out_fault}, {30'b0, 1'b1, flt});
      if (!flt) check({req, " miss paddr"}, out_paddr, {walker_map(v), a[11:0]});
      check({req, " miss word"}, {22'b0, out_word}, {22'b0, a[11:2]});
      if (!flt) begin
        m_val[k] = 1'b1; m_vpn[k] = v; m_ppn[k] = walker_map(v);
      end
      model_inv(ia, ir, s, sz);
      @(posedge clk); #1;
      check({req, " R3 ready back"}, {30'b0, fetch_ready, out_valid}, 32'd2);
    end
  endtask

  task automatic plain(input logic [31:0] a, input string req);
    fetch(a, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, req);
  endtask

  task automatic expect_walk(input logic [31:0] a, input bit want_hit, input string req);
    logic [19:0] v = a[31:12];
    bit k = slot_of(v);
    check({req, " model"}, {31'b0, m_val[k] && (m_vpn[k] == v)}, {31'b0, want_hit});
    plain(a, req);
  endtask

  task automatic invalidate(input bit ia, input bit ir, input logic [31:0] s,
                            input logic [31:0] sz);
    @(negedge clk);
    inv_all = ia; inv_range = ir; inv_start = s; inv_size = sz;
    @(posedge clk); #1;
    inv_all = 1'b0; inv_range = 1'b0;
    model_inv(ia, ir, s, sz);
  endtask

  task automatic t_reset;
    #1;
    check("R1 ready", {29'b0, fetch_ready, walk_req_valid, out_valid}, 32'd4);
    check_counts("R1 counters");
  endtask

  task automatic t_sentinel;
    expect_walk(32'hFFFF_F000, 1'b0, "R12 all-ones page");
  endtask

  task automatic t_fill_hit;
    expect_walk(32'h0000_1234, 1'b0, "R4 first");
    expect_walk(32'h0000_1238, 1'b1, "R4 R2 reuse");
  endtask

  task automatic t_coexist;
    expect_walk(32'h0000_3010, 1'b0, "R5 other slot");
    expect_walk(32'h0000_1000, 1'b1, "R5 slot1 kept");
    expect_walk(32'h0000_3ffc, 1'b1, "R5 slot0 kept");
    expect_walk(32'hFFFF_F004, 1'b0, "R5 same parity evicts");
    expect_walk(32'h0000_3000, 1'b0, "R5 evicted page walks");
  endtask

  task automatic t_fault;
    fetch(32'h0000_5000, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, "R6 fault");
    expect_walk(32'h0000_3004, 1'b1, "R6 slot kept");
    check_counts("R9 counters mid");
  endtask

  task automatic t_flush;
    invalidate(1'b1, 1'b0, 32'h0, 32'h0);
    expect_walk(32'h0000_1000, 1'b0, "R7 after flush");
    expect_walk(32'h0000_3000, 1'b0, "R7 after flush other");
  endtask

  task automatic t_range;
    invalidate(1'b0, 1'b1, 32'h0000_3000, 32'h0000_1000);
    expect_walk(32'h0000_1000, 1'b1, "R8 outside kept");
    expect_walk(32'h0000_3000, 1'b0, "R8 inside dropped");
    invalidate(1'b0, 1'b1, 32'h0000_1000, 32'h0);
    expect_walk(32'h0000_1000, 1'b1, "R8 size zero");
    invalidate(1'b0, 1'b1, 32'h0000_0FFF, 32'h2);
    expect_walk(32'h0000_3000, 1'b1, "R8 end bound other kept");
    expect_walk(32'h0000_1000, 1'b0, "R8 inclusive end");
    invalidate(1'b0, 1'b1, 32'hFFFF_0000, 32'hFFFF_FFFF);
    expect_walk(32'h0000_1000, 1'b1, "R8 wide range below kept");
  endtask

  task automatic t_fill_vs_inv;
    fetch(32'h0000_2000, 1'b0, 1'b0, 1'b1, 32'h0000_2800, 32'h10, "R10 covered fill");
    expect_walk(32'h0000_2000, 1'b0, "R10 covered fill dropped");
    fetch(32'h0000_6000, 1'b0, 1'b0, 1'b1, 32'h0000_9000, 32'h10, "R10 uncovered fill");
    expect_walk(32'h0000_6000, 1'b1, "R10 uncovered fill kept");
  endtask

  task automatic t_hit_vs_inv;
    fetch(32'h0000_6008, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, "R11 hit with flush");
    expect_walk(32'h0000_6008, 1'b0, "R11 flush took effect");
    check_counts("R9 counters end");
  endtask

  initial begin
    for (int e = 0; e < 2; e++) begin
      m_val[e] = 1'b0; m_vpn[e] = '0; m_ppn[e] = '0; m_hit[e] = 0; m_miss[e] = 0;
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_sentinel();
    t_fill_hit();
    t_coexist();
    t_fault();
    t_flush();
    t_range();
    t_fill_vs_inv();
    t_hit_vs_inv();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule